// File: doc/BRIEF.md
# Serial-Programmed DAC Register Controller

This block is the digital front end of a single-channel digital-to-analog converter. A host frames each transfer with an active-low chip select and shifts a command frame in on a serial data line, one bit per rising serial clock edge, most significant bit first. When chip select returns high, the block decodes the 4-bit command at the head of the frame and acts on a double-buffered pair of registers: a staging (input) register and the DAC register that drives the converter code. It also keeps a power-down flag that puts the output into high impedance, and a flag that selects the internal or external reference.

All three serial pins are synchronized into the system clock domain. Serial clock edges and the chip-select rising edge are detected there, so the serial clock must run well below the system clock. Frames of 24 bits and of 32 bits are both accepted, because only the most recent 24 bits shifted in are decoded. The reference mode takes its first value from a strap pin right after reset, and only commands change it after that.

Top module: `dac_serial_ctrl`

## Requirements
- R1: After reset the DAC code output is 0 and the power-down output is 0.
- R2: In the first clock after reset, the reference flag copies the strap pin (1 = internal, 0 = external). Later changes on the pin have no effect. With FORCE_INT_REF=1 the flag starts at 1 whatever the pin is.
- R3: Command 4'b0000 loads the code from the data word into the staging register and leaves the DAC code output unchanged.
- R4: Command 4'b0001 copies the staging register to the DAC code output and clears power-down.
- R5: Command 4'b0011 loads the code from the data word into both the staging register and the DAC code output, and clears power-down.
- R6: Command 4'b0100 sets power-down and keeps the DAC code output unchanged.
- R7: Command 4'b0110 sets the reference flag to internal (1). Command 4'b0111 sets it to external (0).
- R8: Frame layout, MSB first: command in bits 23..20, four ignored bits in 19..16, data word in 15..0. The RES_BITS-bit code is word[15:16-RES_BITS], and the low 16-RES_BITS bits are ignored.
- R9: A 32-bit frame acts like the 24-bit frame formed by its last 24 bits. The serial clock may idle high or low when chip select falls.
- R10: A frame with fewer than 24 rising serial clock edges between the fall and the rise of chip select changes nothing.
- R11: Reserved command codes (any code not listed in R3 to R7) change nothing.
- R12: A command takes effect only after chip select rises. No output changes while chip select is still low, even when a full frame has already been shifted in.
- R13: Commands without a write ignore the data word. For example, 4'b0001 moves the staging register to the output, not the word sent with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Serial chip select, active low; its rising edge executes the frame |
| sck_i | input | 1 | Serial clock; data is taken on its rising edges |
| sdi_i | input | 1 | Serial data in, MSB first |
| ref_strap_i | input | 1 | Power-on reference default (1 = internal) |
| dac_code_o | output | RES_BITS | Current DAC register code |
| pwr_down_o | output | 1 | 1 = output powered down / high impedance |
| ref_int_o | output | 1 | 1 = internal reference, 0 = external |

## Verification
The main path is swept with 64 write-and-update frames. Their codes are spread over the full 12-bit range and their padding bits change from frame to frame, so a slicing error or a leak of padding into the code shows up. Separate write and update frames carry different payloads. This tells double-buffering apart from a direct write, and shows whether an update wrongly takes its payload. Frames of 32 bits with set leading bits, frames sent with the serial clock idling high, 23-bit frames, every reserved code, and a full frame held with chip select low test the framing and execute-on-rise rules one at a time against a model of the registers.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;

  localparam int FRAME_BITS = 24;
  localparam int WORD_BITS  = 16;

  typedef enum logic [3:0] {
    OP_LOAD     = 4'b0000,
    OP_COMMIT   = 4'b0001,
    OP_LOAD_GO  = 4'b0011,
    OP_SLEEP    = 4'b0100,
    OP_REF_INT  = 4'b0110,
    OP_REF_EXT  = 4'b0111
  } op_e;

  typedef struct packed {
    logic [3:0]           op;
    logic [3:0]           unused;
    logic [WORD_BITS-1:0] word;
  } frame_t;

endpackage

// File: rtl/dac_ctrl_sync.sv
module dac_ctrl_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_nxt;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_comb stage_nxt[g] = d_i;
      end else begin : g_rest
        always_comb stage_nxt[g] = stage_q[g-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= stage_nxt[g];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/dac_ctrl_rx.sv
module dac_ctrl_rx
  import dac_ctrl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cs_n_s,
  input  logic   sck_s,
  input  logic   sdi_s,
  output frame_t frame_o,
  output logic   exec_o
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  logic                  sck_d_q, cs_d_q;
  logic [FRAME_BITS-1:0] shift_q, shift_nxt;
  logic [CNT_W-1:0]      cnt_q, cnt_nxt;
  logic                  exec_q, exec_nxt;
  logic                  sck_rise, cs_rise, shift_en;

  assign sck_rise = sck_s & ~sck_d_q;
  assign cs_rise  = cs_n_s & ~cs_d_q;
  assign shift_en = sck_rise & ~cs_n_s;

  always_comb begin
    shift_nxt = shift_q;
    cnt_nxt   = cnt_q;
    if (shift_en) shift_nxt = {shift_q[FRAME_BITS-2:0], sdi_s};
    if (cs_n_s)                          cnt_nxt = '0;
    else if (shift_en && cnt_q != CNT_FULL) cnt_nxt = cnt_q + 1'b1;
    exec_nxt = cs_rise && (cnt_q == CNT_FULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d_q <= 1'b0;
      cs_d_q  <= 1'b1;
      shift_q <= '0;
      cnt_q   <= '0;
      exec_q  <= 1'b0;
    end else begin
      sck_d_q <= sck_s;
      cs_d_q  <= cs_n_s;
      if (shift_en) shift_q <= shift_nxt;
      cnt_q   <= cnt_nxt;
      exec_q  <= exec_nxt;
    end
  end

  assign frame_o = frame_t'(shift_q);
  assign exec_o  = exec_q;

  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

  a_r12_exec_single: assert property (@(posedge clk) disable iff (!rst_n)
    exec_q |=> !exec_q);

  a_r12_no_shift_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s && cs_d_q |=> $stable(shift_q));

endmodule

// File: rtl/dac_ctrl_regs.sv
module dac_ctrl_regs
  import dac_ctrl_pkg::*;
#(
  parameter int RES_BITS      = 12,
  parameter bit FORCE_INT_REF = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                exec_i,
  input  frame_t              frame_i,
  input  logic                ref_strap_i,
  output logic [RES_BITS-1:0] code_o,
  output logic                pd_o,
  output logic                ref_int_o
);

  localparam int CODE_LSB = WORD_BITS - RES_BITS;

  logic [RES_BITS-1:0] in_q, in_nxt;
  logic [RES_BITS-1:0] dac_q, dac_nxt;
  logic                pd_q, pd_nxt;
  logic                ref_q, ref_nxt;
  logic                boot_q;
  logic [RES_BITS-1:0] new_code;
  logic                do_load, do_commit;

  assign new_code = frame_i.word[WORD_BITS-1:CODE_LSB];

  always_comb begin
    do_load   = 1'b0;
    do_commit = 1'b0;
    pd_nxt    = pd_q;
    ref_nxt   = ref_q;
    if (!boot_q) begin
      ref_nxt = FORCE_INT_REF ? 1'b1 : ref_strap_i;
    end
    if (exec_i) begin
      unique case (frame_i.op)
        OP_LOAD:    do_load = 1'b1;
        OP_COMMIT:  begin do_commit = 1'b1; pd_nxt = 1'b0; end
        OP_LOAD_GO: begin do_load = 1'b1; do_commit = 1'b1; pd_nxt = 1'b0; end
        OP_SLEEP:   pd_nxt  = 1'b1;
        OP_REF_INT: ref_nxt = 1'b1;
        OP_REF_EXT: ref_nxt = 1'b0;
        default:    ;
      endcase
    end
    in_nxt  = do_load ? new_code : in_q;
    dac_nxt = dac_q;
    if (do_commit) dac_nxt = do_load ? new_code : in_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= '0;
      dac_q  <= '0;
      pd_q   <= 1'b0;
      ref_q  <= 1'b0;
      boot_q <= 1'b0;
    end else begin
      if (do_load)   in_q  <= in_nxt;
      if (do_commit) dac_q <= dac_nxt;
      pd_q   <= pd_nxt;
      ref_q  <= ref_nxt;
      boot_q <= 1'b1;
    end
  end

  assign code_o    = dac_q;
  assign pd_o      = pd_q;
  assign ref_int_o = ref_q;

  a_r4_commit_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && (frame_i.op == OP_COMMIT || frame_i.op == OP_LOAD_GO) |=> !pd_q);

  a_r6_sleep_holds_code: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && frame_i.op == OP_SLEEP |=> pd_q && $stable(dac_q));

  a_r12_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |=> $stable(dac_q) && $stable(in_q) && $stable(pd_q));

  a_r2_strap_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    boot_q && !exec_i |=> $stable(ref_q));

  a_r11_reserved_inert: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && !(frame_i.op inside {OP_LOAD, OP_COMMIT, OP_LOAD_GO, OP_SLEEP,
                                    OP_REF_INT, OP_REF_EXT})
    |=> $stable(dac_q) && $stable(in_q) && $stable(pd_q) && $stable(ref_q));

  a_r3_load_keeps_output: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && frame_i.op == OP_LOAD |=> $stable(dac_q));

endmodule

// File: rtl/dac_serial_ctrl.sv
module dac_serial_ctrl
  import dac_ctrl_pkg::*;
#(
  parameter int RES_BITS      = 12,
  parameter bit FORCE_INT_REF = 1'b0,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n_i,
  input  logic                sck_i,
  input  logic                sdi_i,
  input  logic                ref_strap_i,
  output logic [RES_BITS-1:0] dac_code_o,
  output logic                pwr_down_o,
  output logic                ref_int_o
);

  logic [2:0] pins_s;
  frame_t     frame;
  logic       exec;

  dac_ctrl_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b001)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({sdi_i, sck_i, cs_n_i}),
    .q_o   (pins_s)
  );

  dac_ctrl_rx u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n_s  (pins_s[0]),
    .sck_s   (pins_s[1]),
    .sdi_s   (pins_s[2]),
    .frame_o (frame),
    .exec_o  (exec)
  );

  dac_ctrl_regs #(
    .RES_BITS      (RES_BITS),
    .FORCE_INT_REF (FORCE_INT_REF)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .exec_i      (exec),
    .frame_i     (frame),
    .ref_strap_i (ref_strap_i),
    .code_o      (dac_code_o),
    .pd_o        (pwr_down_o),
    .ref_int_o   (ref_int_o)
  );

endmodule

// File: tb/dac_serial_ctrl_test.sv
module dac_serial_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int RES        = 12;
  localparam int HALF       = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, strap = 1'b0;
  logic [RES-1:0] code, code_f;
  logic pd, pd_f, refi, refi_f;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [RES-1:0] m_in = '0, m_dac = '0;
  logic m_pd = 1'b0, m_ref = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_serial_ctrl #(.RES_BITS(RES)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .sdi_i(sdi),
    .ref_strap_i(strap), .dac_code_o(code), .pwr_down_o(pd), .ref_int_o(refi));

  dac_serial_ctrl #(.RES_BITS(RES), .FORCE_INT_REF(1'b1)) uut_force (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .sdi_i(sdi),
    .ref_strap_i(1'b0), .dac_code_o(code_f), .pwr_down_o(pd_f), .ref_int_o(refi_f));

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, "code", int'(code), int'(m_dac));
    chk(req, "pwr_down", int'(pd), int'(m_pd));
    chk(req, "ref_int", int'(refi), int'(m_ref));
  endtask

  task automatic clks(int n);
    repeat (n) @(negedge clk);
  endtask

  // shift nbits of val, MSB first, leaving chip select low
  task automatic shift_bits(int nbits, logic [31:0] val, bit idle_hi);
    sck = idle_hi;
    clks(HALF);
    cs_n = 1'b0;
    clks(HALF);
    for (int i = nbits - 1; i >= 0; i--) begin
      sck = 1'b0;
      sdi = val[i];
      clks(HALF);
      sck = 1'b1;
      clks(HALF);
    end
    sck = idle_hi;
    clks(HALF);
  endtask

  task automatic end_frame();
    cs_n = 1'b1;
    sck = 1'b0;
    clks(12);
  endtask

  // model of the requirements
  task automatic model(logic [3:0] op, logic [15:0] word);
    logic [RES-1:0] c;
    c = word[15:16-RES];
    case (op)
      4'b0000: m_in = c;
      4'b0001: begin m_dac = m_in; m_pd = 1'b0; end
      4'b0011: begin m_in = c; m_dac = c; m_pd = 1'b0; end
      4'b0100: m_pd = 1'b1;
      4'b0110: m_ref = 1'b1;
      4'b0111: m_ref = 1'b0;
      default: ;
    endcase
  endtask

  task automatic frame(string req, logic [3:0] op, logic [15:0] word,
                       bit long32, bit idle_hi);
    logic [31:0] v;
    v = {8'hFF, op, 4'hA, word};
    shift_bits(long32 ? 32 : 24, v, idle_hi);
    end_frame();
    model(op, word);
    chk_all(req);
  endtask

  initial begin
    clks(3);
    rst_n = 1'b1;
    clks(3);
    // R1 / R2 reset state
    chk("R1", "code", int'(code), 0);
    chk("R1", "pwr_down", int'(pd), 0);
    chk("R2", "ref_int strap low", int'(refi), 0);
    chk("R2", "forced ref_int", int'(refi_f), 1);
    strap = 1'b1;
    clks(10);
    chk("R2", "ref_int after strap change", int'(refi), 0);

    frame("R3", 4'b0000, 16'hABC5, 1'b0, 1'b0);
    chk("R3", "code unchanged", int'(code), 0);
    frame("R13", 4'b0001, 16'h1234, 1'b0, 1'b0);
    chk("R13", "staged code", int'(code), 12'hABC);
    frame("R6", 4'b0100, 16'hFFFF, 1'b0, 1'b0);
    frame("R5", 4'b0011, 16'h5A3F, 1'b0, 1'b0);
    chk("R5", "code", int'(code), 12'h5A3);
    frame("R6", 4'b0100, 16'h0000, 1'b0, 1'b0);
    frame("R4", 4'b0001, 16'h0000, 1'b0, 1'b0);
    chk("R4", "pwr_down", int'(pd), 0);
    frame("R7", 4'b0110, 16'h0000, 1'b0, 1'b0);
    frame("R7", 4'b0111, 16'hFFFF, 1'b0, 1'b0);
    frame("R7", 4'b0110, 16'h0000, 1'b0, 1'b0);

    // R11 reserved codes
    for (int op = 0; op < 16; op++) begin
      if (!(op inside {0, 1, 3, 4, 6, 7}))
        frame("R11", 4'(op), 16'h9876, 1'b0, 1'b0);
    end

    // R10 short frame
    shift_bits(23, {8'h0, 4'b0011, 4'h0, 16'h7770} >> 1, 1'b0);
    end_frame();
    chk_all("R10");
    shift_bits(23, {8'h0, 4'b0100, 4'h0, 16'h0}, 1'b0);
    end_frame();
    chk_all("R10");

    // R9 32-bit frames and idle-high clock
    frame("R9", 4'b0011, 16'h3C10, 1'b1, 1'b0);
    frame("R9", 4'b0011, 16'hC3E0, 1'b0, 1'b1);
    frame("R9", 4'b0000, 16'h0F0F, 1'b1, 1'b1);
    frame("R9", 4'b0001, 16'hFFFF, 1'b1, 1'b0);

    // R12 full frame held with chip select low
    shift_bits(24, {8'h0, 4'b0011, 4'h0, 16'h1110}, 1'b0);
    clks(20);
    chk_all("R12");
    end_frame();
    model(4'b0011, 16'h1110);
    chk_all("R12");

    // R8 sweep with varying padding
    for (int i = 0; i < 64; i++) begin
      logic [RES-1:0] c;
      c = RES'((i * 1237 + 5) % 4096);
      frame("R8", 4'b0011, {c, 4'(i)}, i[0], i[1]);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule